// File: doc/BRIEF.md
# Line-Sensor Sampling and Channel Sequencer

This block turns a master clock and a periodic sample-sync pulse into the timing strobes that an image-sensor front end needs: a video-sample strobe, a reset-sample strobe, and a clamp strobe that always lands on the reset sample. It also drives the select of the red/green/blue converter multiplexer. A phase counter restarts on every sync pulse and keeps running at the configured clock-to-sync ratio when no further pulse arrives.

Each converter slot is marked with a strobe, a valid flag and a channel code. Slots are two clocks wide in the 6:1 and 8:1 ratios and one per sync period in the 3:1 and 2:1 ratios. The tag goes through a fixed delay line of `LAT` stages, which stands in for the analogue and conversion pipeline. Downstream logic can then keep or drop each converted word without knowing the mode.

Top module: `lsq_sampler_seq`

## Requirements
- R1: Phases are numbered from 1, where phase 1 is the clock cycle that follows the rising edge on which `sync_i` is sampled high. `vs_o` is high only in phase 1. With no further sync pulse, the phase count wraps from the ratio length back to 1. A sync pulse that arrives early restarts the count at phase 1.
- R2: With sampling of the reset level enabled (`cfg_cds_i`=1) in the 6:1 or 8:1 ratio, `rs_o` is high in phase 3, 4, 5 or 6 for `cfg_rpos_i` = 00, 01, 10 or 11.
- R3: In the 3:1 ratio the reset strobe is fixed at phase 3 and `cfg_rpos_i` is ignored. In the 2:1 ratio reset-level sampling is unavailable, so `cfg_cds_i` is ignored and `rs_o` coincides with `vs_o`.
- R4: With `cfg_cds_i`=0, `rs_o` is high in phase 1, together with `vs_o`.
- R5: `clamp_req_i` is captured on the edge that samples the sync pulse. `cl_o` is high exactly when `rs_o` is high in the periods that follow, and only if the captured value was 1.
- R6: `cfg_ratio_i` selects the clocks per sync period: 00 gives 6, 01 gives 3, 10 gives 2 and 11 gives 8. `adc_strobe_o` is high in phases 1, 3, 5 (and 7) for 6 and 8, and in phase 1 only for 3 and 2.
- R7: In colour operation (`cfg_mono_i`=0 with ratio 6 or 8), `mux_sel_o` is 00, 01 and 10 (red, green, blue) in slots 0, 1 and 2. The fourth slot of the 8:1 ratio selects 00.
- R8: In monochrome operation, `mux_sel_o` is held at `cfg_chan_i` (00 red, 01 green, 10 blue), and code 11 selects 00. Ratios 3 and 2 always operate as monochrome.
- R9: A slot is valid as follows: all three slots in colour 6:1, the first three of four in colour 8:1, and only the first slot in every monochrome case.
- R10: The tag for each phase appears on `out_strobe_o`, `out_valid_o` and `out_chan_o` exactly `LAT` (default 4) cycles later. `out_chan_o` equals the mux select of a valid slot and is 11 otherwise.
- R11: While reset is asserted, and after reset until the first sync pulse, all strobes and tag outputs are 0, `out_chan_o` is 11 and `mux_sel_o` is 00 in colour operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Sample-sync pulse, sampled on rising edges |
| clamp_req_i | input | 1 | Per-pixel clamp request |
| cfg_mono_i | input | 1 | 1 = monochrome, 0 = colour |
| cfg_ratio_i | input | 2 | Clock-to-sync ratio code |
| cfg_cds_i | input | 1 | 1 = separate reset-level sample |
| cfg_rpos_i | input | 2 | Reset-sample position code |
| cfg_chan_i | input | 2 | Monochrome channel select |
| vs_o | output | 1 | Video-sample strobe |
| rs_o | output | 1 | Reset-sample strobe |
| cl_o | output | 1 | Clamp strobe |
| mux_sel_o | output | 2 | Converter multiplexer select |
| adc_strobe_o | output | 1 | Start of a converter slot |
| out_strobe_o | output | 1 | Delayed slot strobe |
| out_valid_o | output | 1 | Delayed slot valid flag |
| out_chan_o | output | 2 | Delayed channel code |

## Verification
A phase counter that drifts or fails to restart shows on `vs_o` and `rs_o` in the very next cycle, because both decode the counter directly. A slot map that is wrong shows as a wrong `mux_sel_o` or `adc_strobe_o` in the same cycle. A wrong valid or channel tag appears only `LAT` cycles later, on the delayed outputs. A clamp flag that is captured wrongly shows as `cl_o` missing from, or added to, the next reset strobe. The stimulus table therefore checks every phase of one period and the delayed tags of that period, for each ratio, position code and channel code.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

   typedef enum logic [1:0] {
      RT_STD  = 2'b00,
      RT_FAST = 2'b01,
      RT_MAX  = 2'b10,
      RT_SLOW = 2'b11
   } ratio_e;

   localparam logic [1:0] CH_RED  = 2'b00;
   localparam logic [1:0] CH_NONE = 2'b11;

   typedef struct packed {
      logic       strobe;
      logic       valid;
      logic [1:0] chan;
   } slot_tag_t;

   localparam slot_tag_t TAG_IDLE = '{strobe: 1'b0, valid: 1'b0, chan: CH_NONE};

endpackage

// File: rtl/lsq_phase_ctr.sv
module lsq_phase_ctr #(
   parameter int unsigned PH_W    = 4,
   parameter int unsigned MAX_LEN = 8
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            sync_i,
   input  logic [PH_W-1:0] len_i,
   output logic [PH_W-1:0] phase_o
);

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= '0;
      end else if (sync_i) begin
         phase_q <= PH_W'(1);
      end else if (phase_q != '0) begin
         phase_q <= (phase_q >= len_i) ? PH_W'(1) : phase_q + PH_W'(1);
      end
   end

   assign phase_o = phase_q;

   AST_SYNC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_i |=> (phase_o == PH_W'(1))); // R1
   AST_PHASE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phase_o <= PH_W'(MAX_LEN)); // R6

endmodule

// File: rtl/lsq_strobe_gen.sv
module lsq_strobe_gen import lsq_pkg::*; #(
   parameter int unsigned PH_W       = 4,
   parameter int unsigned RS_NOMINAL = 4,
   parameter int unsigned RS_FAST    = 3
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            sync_i,
   input  logic            clamp_req_i,
   input  logic [PH_W-1:0] phase_i,
   input  ratio_e          ratio_i,
   input  logic            cds_i,
   input  logic [1:0]      rpos_i,
   output logic            vs_o,
   output logic            rs_o,
   output logic            cl_o
);

   logic            arm_q;
   logic            cds_eff;
   logic [PH_W-1:0] rs_ph;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     arm_q <= 1'b0;
      else if (sync_i) arm_q <= clamp_req_i;
   end

   always_comb begin
      cds_eff = cds_i && (ratio_i != RT_MAX);
      if (!cds_eff)                rs_ph = PH_W'(1);
      else if (ratio_i == RT_FAST) rs_ph = PH_W'(RS_FAST);
      else                         rs_ph = PH_W'(RS_NOMINAL - 1) + PH_W'(rpos_i);
   end

   assign vs_o = (phase_i == PH_W'(1));
   assign rs_o = (phase_i != '0) && (phase_i == rs_ph);
   assign cl_o = rs_o && arm_q;

   AST_CL_ON_RS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cl_o |-> rs_o); // R5
   AST_SE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rs_o && !cds_i) |-> vs_o); // R4
   AST_MAX_NO_CDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rs_o && ratio_i == RT_MAX) |-> vs_o); // R3

endmodule

// File: rtl/lsq_slot_map.sv
module lsq_slot_map import lsq_pkg::*; #(
   parameter int unsigned PH_W     = 4,
   parameter int unsigned SLOT_LEN = 2,
   parameter int unsigned NCOL     = 3
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [PH_W-1:0] phase_i,
   input  ratio_e          ratio_i,
   input  logic            mono_i,
   input  logic [1:0]      chan_i,
   output logic [1:0]      mux_o,
   output slot_tag_t       tag_o
);

   logic            two_clk, mono_eff, conv, valid;
   logic [PH_W-1:0] ph0, slot;
   logic [1:0]      chan_m, col_sel;

   always_comb begin
      two_clk  = (ratio_i == RT_STD) || (ratio_i == RT_SLOW);
      mono_eff = mono_i || !two_clk;
      ph0      = phase_i - PH_W'(1);
      if (two_clk) begin
         conv = (phase_i != '0) && ((ph0 % PH_W'(SLOT_LEN)) == '0);
         slot = ph0 / PH_W'(SLOT_LEN);
      end else begin
         conv = (phase_i == PH_W'(1));
         slot = '0;
      end
      chan_m  = (chan_i == CH_NONE) ? CH_RED : chan_i;
      col_sel = (slot < PH_W'(NCOL)) ? slot[1:0] : CH_RED;
      mux_o   = mono_eff ? chan_m : col_sel;
      valid   = conv && (mono_eff ? (slot == '0) : (slot < PH_W'(NCOL)));
      tag_o.strobe = conv;
      tag_o.valid  = valid;
      tag_o.chan   = valid ? mux_o : CH_NONE;
   end

   AST_VALID_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tag_o.valid |-> tag_o.strobe); // R9
   AST_MONO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mono_i && $stable(mono_i) && $stable(chan_i) && $stable(ratio_i)) |-> $stable(mux_o)); // R8

endmodule

// File: rtl/lsq_tag_delay.sv
module lsq_tag_delay import lsq_pkg::*; #(
   parameter int unsigned LAT = 4
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  slot_tag_t tag_i,
   output slot_tag_t tag_o
);

   generate
      if (LAT == 0) begin : g_bypass
         assign tag_o = tag_i;
      end else begin : g_pipe
         slot_tag_t pipe_q [LAT];
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               for (int i = 0; i < LAT; i++) pipe_q[i] <= TAG_IDLE;
            end else begin
               pipe_q[0] <= tag_i;
               for (int i = 1; i < LAT; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign tag_o = pipe_q[LAT-1];
      end
   endgenerate

   AST_IDLE_CHAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tag_o.valid |-> (tag_o.chan == CH_NONE)); // R10

endmodule

// File: rtl/lsq_sampler_seq.sv
module lsq_sampler_seq import lsq_pkg::*; #(
   parameter int unsigned RATIO_STD  = 6,
   parameter int unsigned RATIO_FAST = 3,
   parameter int unsigned RATIO_MAX  = 2,
   parameter int unsigned RATIO_SLOW = 8,
   parameter int unsigned SLOT_LEN   = 2,
   parameter int unsigned NCOL       = 3,
   parameter int unsigned RS_NOMINAL = 4,
   parameter int unsigned RS_FAST    = 3,
   parameter int unsigned LAT        = 4
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       sync_i,
   input  logic       clamp_req_i,
   input  logic       cfg_mono_i,
   input  logic [1:0] cfg_ratio_i,
   input  logic       cfg_cds_i,
   input  logic [1:0] cfg_rpos_i,
   input  logic [1:0] cfg_chan_i,
   output logic       vs_o,
   output logic       rs_o,
   output logic       cl_o,
   output logic [1:0] mux_sel_o,
   output logic       adc_strobe_o,
   output logic       out_strobe_o,
   output logic       out_valid_o,
   output logic [1:0] out_chan_o
);

   localparam int unsigned PH_W = $clog2(RATIO_SLOW + 1);

   generate
      if (RATIO_STD != NCOL * SLOT_LEN) begin : g_bad_std
         $error("standard ratio must hold exactly the colour slots");
      end
      if (RATIO_SLOW != (NCOL + 1) * SLOT_LEN) begin : g_bad_slow
         $error("slow ratio must hold one spare slot");
      end
      if (NCOL > 3) begin : g_bad_ncol
         $error("channel code holds at most three colours");
      end
      if (RS_NOMINAL + 2 > RATIO_STD || RS_NOMINAL < 2) begin : g_bad_rs
         $error("reset position range must fit inside one period");
      end
      if (RS_FAST > RATIO_FAST || RATIO_MAX > RATIO_FAST) begin : g_bad_fast
         $error("fast ratio settings inconsistent");
      end
   endgenerate

   ratio_e          ratio;
   logic [PH_W-1:0] len, phase;
   slot_tag_t       front_tag, back_tag;

   assign ratio = ratio_e'(cfg_ratio_i);

   always_comb begin
      case (ratio)
         RT_STD:  len = PH_W'(RATIO_STD);
         RT_FAST: len = PH_W'(RATIO_FAST);
         RT_MAX:  len = PH_W'(RATIO_MAX);
         default: len = PH_W'(RATIO_SLOW);
      endcase
   end

   lsq_phase_ctr #(.PH_W(PH_W), .MAX_LEN(RATIO_SLOW)) u_ctr (
      .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .len_i(len), .phase_o(phase)
   );

   lsq_strobe_gen #(.PH_W(PH_W), .RS_NOMINAL(RS_NOMINAL), .RS_FAST(RS_FAST)) u_stb (
      .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .clamp_req_i(clamp_req_i),
      .phase_i(phase), .ratio_i(ratio), .cds_i(cfg_cds_i), .rpos_i(cfg_rpos_i),
      .vs_o(vs_o), .rs_o(rs_o), .cl_o(cl_o)
   );

   lsq_slot_map #(.PH_W(PH_W), .SLOT_LEN(SLOT_LEN), .NCOL(NCOL)) u_map (
      .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(phase), .ratio_i(ratio),
      .mono_i(cfg_mono_i), .chan_i(cfg_chan_i), .mux_o(mux_sel_o), .tag_o(front_tag)
   );

   lsq_tag_delay #(.LAT(LAT)) u_dly (
      .clk_i(clk_i), .rst_ni(rst_ni), .tag_i(front_tag), .tag_o(back_tag)
   );

   assign adc_strobe_o = front_tag.strobe;
   assign out_strobe_o = back_tag.strobe;
   assign out_valid_o  = back_tag.valid;
   assign out_chan_o   = back_tag.chan;

   AST_STROBE_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adc_strobe_o |-> (phase != '0)); // R11

endmodule

// File: tb/sim_lsq_sampler_seq.sv
`timescale 1ns/1ps
module sim_lsq_sampler_seq;

   localparam int LAT = 4;

   typedef struct packed {
      logic [1:0]  ratio;
      logic        mono;
      logic        cds;
      logic [1:0]  rpos;
      logic [1:0]  chan;
      logic        clamp;
      logic [3:0]  rsph;
      logic [7:0]  conv;
      logic [7:0]  valid;
      logic [15:0] mux;
   } vec_t;

   // ratio mono cds rpos chan clamp | rs phase, strobe mask, valid mask, mux per phase
   localparam vec_t TBL [11] = '{
      '{2'd0, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1, 4'd4, 8'h15, 8'h15, 16'h0A50},
      '{2'd0, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 4'd3, 8'h15, 8'h15, 16'h0A50},
      '{2'd0, 1'b0, 1'b1, 2'd2, 2'd0, 1'b1, 4'd5, 8'h15, 8'h15, 16'h0A50},
      '{2'd0, 1'b0, 1'b1, 2'd3, 2'd0, 1'b1, 4'd6, 8'h15, 8'h15, 16'h0A50},
      '{2'd0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b1, 4'd1, 8'h15, 8'h15, 16'h0A50},
      '{2'd0, 1'b1, 1'b1, 2'd1, 2'd1, 1'b0, 4'd4, 8'h15, 8'h01, 16'h0555},
      '{2'd0, 1'b1, 1'b1, 2'd1, 2'd3, 1'b0, 4'd4, 8'h15, 8'h01, 16'h0000},
      '{2'd1, 1'b0, 1'b1, 2'd2, 2'd2, 1'b1, 4'd3, 8'h01, 8'h01, 16'h002A},
      '{2'd2, 1'b0, 1'b1, 2'd3, 2'd1, 1'b1, 4'd1, 8'h01, 8'h01, 16'h0005},
      '{2'd3, 1'b0, 1'b1, 2'd2, 2'd0, 1'b0, 4'd5, 8'h55, 8'h15, 16'h0A50},
      '{2'd3, 1'b1, 1'b1, 2'd1, 2'd2, 1'b1, 4'd4, 8'h55, 8'h01, 16'hAAAA}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync = 1'b0, clamp = 1'b0, mono = 1'b0, cds = 1'b1;
   logic [1:0] ratio = 2'd0, rpos = 2'd1, chan = 2'd0;
   logic       vs, rs, cl, adc_stb, o_stb, o_val;
   logic [1:0] mux, o_chan;

   int checks = 0;
   int bad = 0;

   always #2 clk = ~clk;

   lsq_sampler_seq u0 (
      .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .clamp_req_i(clamp),
      .cfg_mono_i(mono), .cfg_ratio_i(ratio), .cfg_cds_i(cds), .cfg_rpos_i(rpos),
      .cfg_chan_i(chan), .vs_o(vs), .rs_o(rs), .cl_o(cl), .mux_sel_o(mux),
      .adc_strobe_o(adc_stb), .out_strobe_o(o_stb), .out_valid_o(o_val),
      .out_chan_o(o_chan)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
      end
   endtask

   function automatic int rlen(input logic [1:0] code);
      case (code)
         2'd0: return 6;
         2'd1: return 3;
         2'd2: return 2;
         default: return 8;
      endcase
   endfunction

   task automatic chk_idle(input string req);
      chk(req, {28'd0, vs, rs, cl, adc_stb}, 32'd0);
      chk(req, {28'd0, o_stb, o_val, o_chan}, 32'h3);
   endtask

   initial begin
      #(4 * 200000);
      checks++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      // R11: reset state and idle before the first sync
      repeat (3) @(negedge clk);
      chk_idle("R11 in reset");
      chk("R11 mux in reset", {30'd0, mux}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk_idle("R11 idle after reset");

      // table walk
      for (int e = 0; e < 11; e++) begin
         vec_t v;
         int len;
         v = TBL[e];
         len = rlen(v.ratio);
         @(negedge clk);
         ratio = v.ratio; mono = v.mono; cds = v.cds; rpos = v.rpos;
         chan = v.chan; clamp = v.clamp; sync = 1'b1;
         for (int c = 0; c < len + LAT; c++) begin
            @(negedge clk);
            sync = 1'b0;
            if (c < len) begin
               chk("R1 vs", {31'd0, vs}, {31'd0, c == 0});
               chk("R2 R3 R4 rs", {31'd0, rs}, {31'd0, (c + 1) == int'(v.rsph)});
               chk("R5 cl", {31'd0, cl}, {31'd0, ((c + 1) == int'(v.rsph)) && v.clamp});
               chk("R6 adc strobe", {31'd0, adc_stb}, {31'd0, v.conv[c]});
               chk("R7 R8 mux", {30'd0, mux}, {30'd0, v.mux[2*c +: 2]});
            end
            if (c >= LAT && (c - LAT) < len) begin
               int f;
               f = c - LAT;
               chk("R10 out strobe", {31'd0, o_stb}, {31'd0, v.conv[f]});
               chk("R9 out valid", {31'd0, o_val}, {31'd0, v.valid[f]});
               chk("R10 out chan", {30'd0, o_chan},
                   {30'd0, v.valid[f] ? v.mux[2*f +: 2] : 2'b11});
            end
         end
      end

      // R1: early sync restarts, then free running wrap
      @(negedge clk);
      ratio = 2'd0; mono = 1'b0; cds = 1'b1; rpos = 2'd1; clamp = 1'b0; sync = 1'b1;
      @(negedge clk); sync = 1'b0;                    // c0
      chk("R1 first vs", {31'd0, vs}, 32'd1);
      @(negedge clk);                                 // c1
      @(negedge clk); sync = 1'b1;                    // c2
      @(negedge clk); sync = 1'b0;                    // c3
      chk("R1 restart vs", {31'd0, vs}, 32'd1);
      chk("R1 old rs dropped", {31'd0, rs}, 32'd0);
      repeat (3) @(negedge clk);                      // c6
      chk("R1 R2 rs after restart", {31'd0, rs}, 32'd1);
      repeat (2) @(negedge clk);                      // c8
      chk("R1 no vs before wrap", {31'd0, vs}, 32'd0);
      @(negedge clk);                                 // c9
      chk("R1 vs on wrap", {31'd0, vs}, 32'd1);

      // R11: reset in mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk_idle("R11 mid-run reset");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk_idle("R11 idle until sync");

      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule